// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block forms the Montgomery product T ≡ A·B·R⁻¹ (mod N) with a single 16-bit multiply-accumulate datapath. The operands sit in word-addressed memories outside the block. For a modulus of s words, set at run time with `lenWords`, R is 2^(16·(s+1)). The block reads A, B and N one word at a time through three synchronous read ports, which return data one cycle after the address. It writes T word by word through a result port. The caller supplies the per-modulus constant n0Prime = −N₀⁻¹ mod 2^16, where N₀ is the lowest modulus word.

The block makes one outer pass per word of A, s+1 passes in all. Each pass forms a quotient word, adds a_i·B + q·N into an internal partial sum of s+2 words, and then drops the low word of that sum. R carries one extra word beyond the modulus length, so inputs below 2N always give an output below 2N. The block therefore has no final conditional subtraction, and the result can go straight back in as the next operand in an exponentiation chain.

Top module: `mont_mul_word`

## Requirements
- R1: For any odd N of s words (1 ≤ s ≤ 64) and A, B < 2N, the written result T satisfies T·2^(16·(s+1)) ≡ A·B (mod N).
- R2: Under the conditions of R1, T < 2N with no final subtraction, including moduli whose top word is 0xFFFF and operands equal to 2N−1. Such a result is accepted as an operand of a further multiplication, and R1 and R2 hold for that multiplication too.
- R3: A and B are read as s+1 words at addresses 0..s, least significant first. N is read as s words. The result is written as s+1 words, one per cycle with `resWe` high, to addresses 0 to s in ascending order, least significant first.
- R4: In every outer pass, the low word dropped from the partial sum is zero.
- R5: `done` is high for exactly one cycle. It rises (s+1)·(s+6) clock edges after the edge that samples `start`, which is the cycle right after the last result write.
- R6: `start` is ignored while an operation is running. A second pulse, even with a different `lenWords`, changes neither the latency nor the result, and produces no extra `done`.
- R7: With A = 0, every result word is zero.
- R8: After reset, `done` and `resWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (sampled when idle) |
| lenWords | input | 7 | Modulus length s in 16-bit words, 1..64 |
| n0Prime | input | 16 | −N₀⁻¹ mod 2^16 |
| aAddr | output | 7 | Word address into operand A memory |
| aData | input | 16 | A word, one cycle after aAddr |
| bAddr | output | 7 | Word address into operand B memory |
| bData | input | 16 | B word, one cycle after bAddr |
| nAddr | output | 7 | Word address into modulus memory |
| nData | input | 16 | N word, one cycle after nAddr |
| resAddr | output | 7 | Result word address |
| resData | output | 16 | Result word |
| resWe | output | 1 | Result write strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each outer pass takes s+5 cycles: an A fetch, a quotient cycle, s+2 word steps and one drain cycle. The s+1 result writes follow, and `done` comes in the next cycle. The total is therefore (s+1)·(s+6) edges after the start edge. The bench records the cycle count at the start edge and compares it with the count on the negative edge where `done` is seen. Write words are taken on negative edges while `resWe` is high and checked against their expected address. The monitor pops the expected congruence class from the scoreboard only when `done` arrives.

// File: rtl/mmw_pkg.sv
package mmw_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = 64;
  localparam int T_WORDS   = MAX_WORDS + 2;
  localparam int IDX_W     = $clog2(T_WORDS);
  localparam int LEN_W     = $clog2(MAX_WORDS + 1);
  localparam int SUM_W     = 2 * WORD_W + 3;
  localparam int CARRY_W   = SUM_W - WORD_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LDA, S_QC, S_INNER, S_DRAIN, S_WR, S_DONE
  } mmw_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             clrT;
    logic             loadQ;
    logic             accEn;
    logic             accFirst;
    logic [IDX_W-1:0] accIdx;
    logic [LEN_W-1:0] lenS;
    logic [IDX_W-1:0] wrIdx;
  } mmw_strobe_t;
endpackage

// File: rtl/mmw_ctrl.sv
module mmw_ctrl
  import mmw_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] lenWords,
  output logic [IDX_W-1:0] aAddr,
  output logic [IDX_W-1:0] bAddr,
  output logic [IDX_W-1:0] nAddr,
  output logic [IDX_W-1:0] resAddr,
  output logic             resWe,
  output logic             done,
  output logic             busy,
  output mmw_strobe_t      st
);
  mmw_state_e       state;
  logic [LEN_W-1:0] lenS;
  logic [IDX_W-1:0] iCnt, jCnt, kCnt;
  logic             accEnD;
  logic [IDX_W-1:0] accIdxD;
  logic [IDX_W-1:0] lenIdx, lastJ;

  assign lenIdx = IDX_W'(lenS);
  assign lastJ  = lenIdx + IDX_W'(1);

  always_comb begin
    aAddr       = iCnt;
    bAddr       = (state == S_INNER) ? jCnt : '0;
    nAddr       = jCnt;
    resAddr     = kCnt;
    resWe       = (state == S_WR);
    done        = (state == S_DONE);
    busy        = (state != S_IDLE);
    st.clrT     = (state == S_IDLE) && start;
    st.loadQ    = (state == S_QC);
    st.accEn    = accEnD;
    st.accFirst = (accIdxD == '0);
    st.accIdx   = accIdxD;
    st.lenS     = lenS;
    st.wrIdx    = kCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      lenS    <= '0;
      iCnt    <= '0;
      jCnt    <= '0;
      kCnt    <= '0;
      accEnD  <= 1'b0;
      accIdxD <= '0;
    end else begin
      accEnD  <= (state == S_INNER);
      accIdxD <= jCnt;
      case (state)
        S_IDLE: if (start) begin
          lenS  <= lenWords;
          iCnt  <= '0;
          state <= S_LDA;
        end
        S_LDA: state <= S_QC;
        S_QC: begin
          jCnt  <= '0;
          state <= S_INNER;
        end
        S_INNER: begin
          jCnt <= jCnt + IDX_W'(1);
          if (jCnt == lastJ) state <= S_DRAIN;
        end
        S_DRAIN: begin
          if (iCnt == lenIdx) begin
            kCnt  <= '0;
            state <= S_WR;
          end else begin
            iCnt  <= iCnt + IDX_W'(1);
            state <= S_LDA;
          end
        end
        S_WR: begin
          kCnt <= kCnt + IDX_W'(1);
          if (kCnt == lenIdx) state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmw_datapath.sv
module mmw_datapath
  import mmw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mmw_strobe_t       st,
  input  logic [WORD_W-1:0] n0Prime,
  input  logic [WORD_W-1:0] aData,
  input  logic [WORD_W-1:0] bData,
  input  logic [WORD_W-1:0] nData,
  output logic [WORD_W-1:0] resData,
  output logic [WORD_W-1:0] accLow
);
  logic [WORD_W-1:0]   tMem [T_WORDS];
  logic [WORD_W-1:0]   aReg, qReg;
  logic [CARRY_W-1:0]  carry;
  logic [WORD_W-1:0]   bIn, nIn, tCur, abLow, qSum, qNext;
  logic [2*WORD_W-1:0] prodB, prodN;
  logic [SUM_W-1:0]    sum;
  logic [IDX_W-1:0]    lenIdx, lastIdx, prevIdx;

  assign lenIdx  = IDX_W'(st.lenS);
  assign lastIdx = lenIdx + IDX_W'(1);
  assign prevIdx = st.accIdx - IDX_W'(1);

  always_comb begin
    // B has s+1 words, N has s words; beyond that the words read as zero
    bIn   = (st.accIdx <= lenIdx) ? bData : '0;
    nIn   = (st.accIdx <  lenIdx) ? nData : '0;
    tCur  = tMem[st.accIdx];
    prodB = (2*WORD_W)'(aReg) * (2*WORD_W)'(bIn);
    prodN = (2*WORD_W)'(qReg) * (2*WORD_W)'(nIn);
    sum   = SUM_W'(tCur) + SUM_W'(prodB) + SUM_W'(prodN)
          + (st.accFirst ? '0 : SUM_W'(carry));
    abLow = aData * bData;
    qSum  = tMem[0] + abLow;
    qNext = qSum * n0Prime;
    accLow  = sum[WORD_W-1:0];
    resData = tMem[st.wrIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.clrT) begin
      for (int k = 0; k < T_WORDS; k++) tMem[k] <= '0;
      aReg  <= '0;
      qReg  <= '0;
      carry <= '0;
    end else begin
      if (st.loadQ) begin
        aReg <= aData;
        qReg <= qNext;
      end
      if (st.accEn) begin
        carry <= sum[SUM_W-1:WORD_W];
        if (st.accIdx != '0) tMem[prevIdx] <= sum[WORD_W-1:0];
        if (st.accIdx == lastIdx) tMem[st.accIdx] <= sum[2*WORD_W-1:WORD_W];
      end
    end
  end
endmodule

// File: rtl/mont_mul_word.sv
module mont_mul_word
  import mmw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenWords,
  input  logic [WORD_W-1:0] n0Prime,
  output logic [IDX_W-1:0]  aAddr,
  input  logic [WORD_W-1:0] aData,
  output logic [IDX_W-1:0]  bAddr,
  input  logic [WORD_W-1:0] bData,
  output logic [IDX_W-1:0]  nAddr,
  input  logic [WORD_W-1:0] nData,
  output logic [IDX_W-1:0]  resAddr,
  output logic [WORD_W-1:0] resData,
  output logic              resWe,
  output logic              done
);
  mmw_strobe_t       st;
  logic              busy;
  logic [WORD_W-1:0] accLow;

  mmw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenWords(lenWords),
    .aAddr(aAddr), .bAddr(bAddr), .nAddr(nAddr), .resAddr(resAddr),
    .resWe(resWe), .done(done), .busy(busy), .st(st)
  );

  mmw_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .n0Prime(n0Prime),
    .aData(aData), .bData(bData), .nData(nData),
    .resData(resData), .accLow(accLow)
  );
endmodule

// File: rtl/mmw_checker.sv
module mmw_checker
  import mmw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              resWe,
  input logic [IDX_W-1:0]  resAddr,
  input logic              busy,
  input logic              accEn,
  input logic              accFirst,
  input logic [WORD_W-1:0] accLow,
  input logic [LEN_W-1:0]  lenS
);
  AST_DROP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accFirst |-> accLow == '0); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(resWe)); // R5
  AST_WR_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    resWe && $past(resWe) |-> resAddr == $past(resAddr) + IDX_W'(1)); // R3
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    resWe |-> resAddr <= IDX_W'(lenS)); // R3
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(lenS)); // R6
endmodule

bind mont_mul_word mmw_checker u_chk (
  .clk(clk), .rstN(rstN), .done(done), .resWe(resWe), .resAddr(resAddr),
  .busy(busy), .accEn(st.accEn), .accFirst(st.accFirst), .accLow(accLow),
  .lenS(st.lenS)
);

// File: tb/tb_mont_mul_word.sv
module tb_mont_mul_word;
  localparam int WB = 16 * 66;
  typedef logic [2*WB+31:0] big_t;
  typedef struct {
    int   s;
    big_t n;
    big_t ab;
    bit   zero;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  lenWords = '0;
  logic [15:0] n0Prime = '0;
  logic [6:0]  aAddr, bAddr, nAddr, resAddr;
  logic [15:0] aData, bData, nData, resData;
  logic        resWe, done;

  logic [15:0] memA [0:127];
  logic [15:0] memB [0:127];
  logic [15:0] memN [0:127];

  int   errors = 0, checks = 0, cyc = 0, startCyc = 0, gotCnt = 0;
  bit   opDone = 0;
  big_t gathered, lastRes;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    aData <= memA[aAddr];
    bData <= memB[bAddr];
    nData <= memN[nAddr];
  end

  mont_mul_word dut (
    .clk(clk), .rstN(rstN), .start(start), .lenWords(lenWords),
    .n0Prime(n0Prime), .aAddr(aAddr), .aData(aData), .bAddr(bAddr),
    .bData(bData), .nAddr(nAddr), .nData(nData), .resAddr(resAddr),
    .resData(resData), .resWe(resWe), .done(done)
  );

  task automatic check(input bit ok, input string req, input big_t act, input big_t exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: collects written words, pops the scoreboard on done
  always @(negedge clk) begin
    if (rstN && resWe) begin
      check(resAddr == 7'(gotCnt), "R3 write order", big_t'(resAddr), big_t'(gotCnt));
      gathered[16*resAddr +: 16] = resData;
      gotCnt++;
    end
    if (rstN && done) begin
      exp_t e;
      big_t lhs;
      e = sb.pop_front();
      check(cyc - startCyc == (e.s + 1) * (e.s + 6), "R5 latency",
            big_t'(cyc - startCyc), big_t'((e.s + 1) * (e.s + 6)));
      check(gotCnt == e.s + 1, "R3 word count", big_t'(gotCnt), big_t'(e.s + 1));
      lhs = (gathered << (16 * (e.s + 1))) % e.n;
      check(lhs == e.ab, "R1 congruence", lhs, e.ab);
      check(gathered < 2 * e.n, "R2 below 2N", gathered, 2 * e.n);
      if (e.zero) check(gathered == '0, "R7 zero operand", gathered, '0);
      lastRes = gathered;
      opDone = 1;
    end
  end

  function automatic big_t randMod(int s, bit topOnes);
    big_t v = '0;
    for (int k = 0; k < s; k++) v[16*k +: 16] = 16'($urandom);
    v[0] = 1'b1;
    if (topOnes) v[16*(s-1) +: 16] = 16'hFFFF;
    else if (v[16*(s-1) +: 16] == '0) v[16*(s-1)] = 1'b1;
    return v;
  endfunction

  function automatic big_t randBelow(int s, big_t lim);
    big_t v = '0;
    for (int k = 0; k <= s; k++) v[16*k +: 16] = 16'($urandom);
    return v % lim;
  endfunction

  function automatic logic [15:0] negInv(logic [15:0] n0);
    logic [15:0] x = n0;
    for (int k = 0; k < 4; k++) x = x * (16'd2 - n0 * x);
    return -x;
  endfunction

  task automatic runOp(input int s, input big_t a, input big_t b, input big_t n,
                       input bit restart);
    exp_t e;
    for (int k = 0; k < 128; k++) begin
      memA[k] = (k <= s) ? a[16*k +: 16] : 16'hDEAD;
      memB[k] = (k <= s) ? b[16*k +: 16] : 16'hBEEF;
      memN[k] = (k < s)  ? n[16*k +: 16] : 16'hCAFE;
    end
    e.s = s; e.n = n; e.ab = (a * b) % n; e.zero = (a == '0);
    sb.push_back(e);
    gotCnt = 0; gathered = '0; opDone = 0;
    @(negedge clk);
    lenWords = 7'(s); n0Prime = negInv(n[15:0]); start = 1'b1;
    @(posedge clk); #1 startCyc = cyc;
    @(negedge clk); start = 1'b0;
    if (restart) begin // R6: second start mid-run with another length
      repeat (4) @(negedge clk);
      lenWords = 7'(s + 1); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (opDone);
    repeat (3) @(negedge clk);
    check(sb.size() == 0 && !done, "R6 single done", big_t'(sb.size()), '0);
  endtask

  initial begin
    big_t n, a, b;
    for (int k = 0; k < 128; k++) begin memA[k] = '0; memB[k] = '0; memN[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !resWe, "R8 reset state", big_t'({done, resWe}), '0);
    // R1 smallest length
    n = randMod(1, 0); runOp(1, randBelow(1, 2*n), randBelow(1, 2*n), n, 0);
    // R1 two words
    n = randMod(2, 0); runOp(2, randBelow(2, 2*n), randBelow(2, 2*n), n, 0);
    // R2 top word all ones, operands at 2N-1
    n = randMod(4, 1); runOp(4, 2*n - 1, 2*n - 1, n, 0);
    // R2 feedback: previous result used as both operands
    runOp(4, lastRes, lastRes, n, 0);
    // R7 zero operand
    n = randMod(3, 0); runOp(3, '0, randBelow(3, 2*n), n, 0);
    // R6 start while busy
    n = randMod(2, 1); runOp(2, randBelow(2, 2*n), randBelow(2, 2*n), n, 1);
    // R1 largest length with top word all ones
    n = randMod(64, 1); runOp(64, randBelow(64, 2*n), 2*n - 1, n, 0);
    a = lastRes; b = randBelow(64, 2*n);
    runOp(64, a, b, n, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule